// File: doc/BRIEF.md
# Serial Peripheral Master with Byte Queues

This block is a master for a four-wire style serial peripheral bus that leaves chip select to the surrounding logic. Software queues outgoing characters through a data write port. A shift engine takes each queued character, drives it bit by bit on MOSI while it generates the serial clock, and samples MISO on the opposite clock edge. Every completed character goes into a small receive queue, and software drains that queue through a data read port.

A four-bit status word reports four conditions: the transmitter is idle, the transmit queue has a free slot, unread receive data is present, and a receive overflow has occurred. An overflow also produces a single-cycle interrupt pulse. Clock polarity, clock phase, bit order and a half-period divider come in as configuration inputs. They are meant to be changed only while the transmitter is idle.

Top module: `spi_byte_master`

## Requirements
- R1: `sclk` rests at `cfg_cpol` whenever the transmitter is idle. Each 8-bit character takes exactly 16 `sclk` transitions, spaced `cfg_div`+1 clock cycles apart. The block has no chip-select output.
- R2: Each queue holds 4 characters. A write while the transmit queue holds 4 characters is discarded and is never sent.
- R3: `status[0]` (transmit idle) drops in the cycle after a write is accepted. It rises only when the transmit queue is empty and the last character has been fully clocked out.
- R4: `status[1]` (transmit free) is low while the transmit queue holds 4 characters. It returns high when the shift engine takes the oldest character, while that character is still shifting.
- R5: `status[2]` (receive valid) is high while the receive queue holds unread characters. `rd_data` shows the oldest one, and `rd_en` removes it.
- R6: A character that completes while the receive queue is full and `rd_en` is low is dropped. In that case `status[3]` sets and `irq_rx_ovf` pulses for one cycle. If `rd_en` is high in the cycle of completion, the read makes room and nothing is lost.
- R7: `status[3]` stays set through draining of the receive queue. Only a one-cycle pulse on `stat_w1c_ovf` clears it.
- R8: With `cfg_lsb_first`=0 bit 7 goes out first and bit 0 last. With `cfg_lsb_first`=1 the order is reversed. Receive assembly uses the same order.
- R9: With `cfg_cpha`=0 the first bit is on MOSI before the first clock edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With `cfg_cpha`=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R10: While the receive queue is empty, `rd_data` reads 0, and an `rd_en` pulse changes no status and loses no later data.
- R11: Queued characters follow one another with no idle gap: the clock spacing stays uniform across character boundaries.
- R12: After reset, `status` is 4'b0011, `irq_rx_ovf` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Half-period of `sclk`, in clock cycles, minus one |
| cfg_cpol | input | 1 | Resting level of `sclk` |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| wr_en | input | 1 | Pushes `wr_data` into the transmit queue |
| wr_data | input | 8 | Character to transmit |
| rd_en | input | 1 | Pops the oldest received character |
| rd_data | output | 8 | Oldest received character, or 0 when the queue is empty |
| stat_w1c_ovf | input | 1 | Status write with a one in the overflow position |
| status | output | 4 | {overflow, receive valid, transmit free, transmit idle} |
| irq_rx_ovf | output | 1 | One-cycle pulse when a received character is dropped |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The delicate collision is a character completing into a full receive queue in the very cycle that software reads the queue. This must not count as an overflow. The bench fills the receive queue, sends one more character, and counts serial clock transitions so that it can raise `rd_en` exactly on the cycle of the sixteenth transition. It then expects no interrupt, a clear overflow bit, and the four newest characters in order. A second run of the same fill without the read must drop the fifth character, set the sticky bit and pulse the interrupt once.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int CHAR_W         = 8;
    localparam int EDGES_PER_CHAR = 2 * CHAR_W;
    localparam int EDGE_CNT_W     = $clog2(EDGES_PER_CHAR);

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic lsb_first;
        logic cpol;
        logic cpha;
    } spim_mode_t;

    typedef struct packed {
        logic rx_ovf;
        logic rx_valid;
        logic tx_free;
        logic tx_idle;
    } spim_stat_t;

    // Insert one received bit into the partial character.
    function automatic logic [CHAR_W-1:0] spim_shift_in(
        input logic [CHAR_W-1:0] cur,
        input logic              b,
        input logic              lsb_first
    );
        return lsb_first ? {b, cur[CHAR_W-1:1]} : {cur[CHAR_W-2:0], b};
    endfunction

    // Advance the transmit register by one bit.
    function automatic logic [CHAR_W-1:0] spim_shift_out(
        input logic [CHAR_W-1:0] cur,
        input logic              lsb_first
    );
        return lsb_first ? {1'b0, cur[CHAR_W-1:1]} : {cur[CHAR_W-2:0], 1'b0};
    endfunction

    // Bit currently presented on the line.
    function automatic logic spim_line_bit(
        input logic [CHAR_W-1:0] cur,
        input logic              lsb_first
    );
        return lsb_first ? cur[0] : cur[CHAR_W-1];
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    // A pop in the same cycle frees the slot a push needs.
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= ptr_inc(wp);
            if (do_pop)  rp <= ptr_inc(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spim_mode_t        mode,
    input  logic              tick,
    input  logic              tx_avail,
    input  logic [CHAR_W-1:0] tx_byte,
    input  logic              miso,
    output logic              tx_take,
    output logic              rx_done,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              mosi,
    output logic              sclk_raw,
    output logic              busy
);
    sh_state_e             state;
    logic [EDGE_CNT_W-1:0] hcnt;
    logic [CHAR_W-1:0]     txs, rxs, rx_next;
    logic                  sclk_q, edge_now, last_edge, lead_edge, sample_now, shift_now;

    assign busy      = (state == SH_RUN);
    assign edge_now  = busy && tick;
    assign lead_edge = !hcnt[0];
    assign last_edge = (hcnt == EDGE_CNT_W'(EDGES_PER_CHAR - 1));

    // Phase 0: sample on leading edges, change on trailing edges (except the last).
    // Phase 1: change on leading edges (except the first), sample on trailing edges.
    assign sample_now = edge_now && (mode.cpha ? !lead_edge : lead_edge);
    assign shift_now  = edge_now && (mode.cpha ? (lead_edge && hcnt != '0)
                                               : (!lead_edge && !last_edge));

    assign rx_next  = sample_now ? spim_shift_in(rxs, miso, mode.lsb_first) : rxs;
    assign rx_done  = edge_now && last_edge;
    assign rx_byte  = rx_next;
    assign tx_take  = tx_avail && (!busy || (edge_now && last_edge));
    assign mosi     = spim_line_bit(txs, mode.lsb_first);
    assign sclk_raw = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            hcnt   <= '0;
            txs    <= '0;
            rxs    <= '0;
            sclk_q <= 1'b0;
        end else begin
            if (edge_now) begin
                sclk_q <= ~sclk_q;
                hcnt   <= hcnt + 1'b1;
                rxs    <= rx_next;
                if (shift_now) txs <= spim_shift_out(txs, mode.lsb_first);
                if (last_edge) state <= SH_IDLE;
            end
            if (tx_take) begin
                txs    <= tx_byte;
                rxs    <= '0;
                hcnt   <= '0;
                sclk_q <= 1'b0;
                state  <= SH_RUN;
            end
        end
    end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    input  logic             stat_w1c_ovf,
    output logic [3:0]       status,
    output logic             irq_rx_ovf,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    spim_mode_t        mode;
    spim_stat_t        stat;
    logic              tx_full, tx_empty, tx_take;
    logic [CHAR_W-1:0] tx_head;
    logic              rx_full, rx_empty, rx_done;
    logic [CHAR_W-1:0] rx_head, rx_byte;
    logic              tick, busy, sclk_raw, drop, ovf_q, irq_q;

    assign mode = '{lsb_first: cfg_lsb_first, cpol: cfg_cpol, cpha: cfg_cpha};

    spim_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_en), .din(wr_data),
        .pop(tx_take), .dout(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_done), .din(rx_byte),
        .pop(rd_en), .dout(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy), .div(cfg_div), .tick(tick)
    );

    spim_shifter u_shift (
        .clk(clk), .rst(rst), .mode(mode), .tick(tick),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso),
        .tx_take(tx_take), .rx_done(rx_done), .rx_byte(rx_byte),
        .mosi(mosi), .sclk_raw(sclk_raw), .busy(busy)
    );

    // A full queue only drops when no read frees a slot in the same cycle.
    assign drop = rx_done && rx_full && !rd_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= drop;
            if (drop) begin
                ovf_q <= 1'b1;
            end else if (stat_w1c_ovf) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign stat.tx_idle  = tx_empty && !busy;
    assign stat.tx_free  = !tx_full;
    assign stat.rx_valid = !rx_empty;
    assign stat.rx_ovf   = ovf_q;

    assign status     = stat;
    assign irq_rx_ovf = irq_q;
    assign rd_data    = rx_empty ? '0 : rx_head;
    assign sclk       = sclk_raw ^ cfg_cpol;

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] status,
    input logic       irq_rx_ovf,
    input logic [7:0] rd_data,
    input logic       sclk,
    input logic       cfg_cpol,
    input logic       stat_w1c_ovf,
    input logic       wr_en
);
    p_sclk_rest_r1: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> (sclk == cfg_cpol));

    p_write_leaves_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (status[0] && wr_en) |=> !status[0]);

    p_idle_has_room_r4: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> status[1]);

    p_irq_marks_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        irq_rx_ovf |-> status[3]);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        irq_rx_ovf |=> !irq_rx_ovf);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !stat_w1c_ovf) |=> status[3]);

    p_empty_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !status[2] |-> (rd_data == 8'h00));

endmodule

bind spi_byte_master spim_checker u_chk (
    .clk(clk), .rst(rst), .status(status), .irq_rx_ovf(irq_rx_ovf),
    .rd_data(rd_data), .sclk(sclk), .cfg_cpol(cfg_cpol),
    .stat_w1c_ovf(stat_w1c_ovf), .wr_en(wr_en)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_div = 8'd1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, stat_w1c_ovf = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] status;
    logic       irq_rx_ovf, sclk, mosi, miso;
    logic       miso_inv = 1'b0;

    always #2 clk = ~clk;

    assign miso = mosi ^ miso_inv;

    spi_byte_master u_dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .stat_w1c_ovf(stat_w1c_ovf), .status(status), .irq_rx_ovf(irq_rx_ovf),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_cmp = 0, n_bad = 0;
    int cyc = 0, irq_cnt = 0;
    logic mosi_n = 1'b0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    // Negative-edge snapshots: the values held just before the next active edge.
    always @(negedge clk) begin
        cyc++;
        mosi_n = mosi;
        if (irq_rx_ovf === 1'b1) irq_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural slave: captures MOSI on the sampling edge for the configured phase.
    logic       mon_en = 1'b0, have_last = 1'b0;
    int         toggles = 0, gap_err = 0, last_cyc = 0, nbits = 0;
    logic [7:0] sh = 8'h00;

    always @(sclk) begin
        if (mon_en && !$isunknown(sclk)) begin
            toggles++;
            if (have_last && (cyc - last_cyc) != int'(cfg_div) + 1) gap_err++;
            last_cyc  = cyc;
            have_last = 1'b1;
            if ((sclk != cfg_cpol) ^ cfg_cpha) begin
                sh = cfg_lsb_first ? {mosi_n, sh[7:1]} : {sh[6:0], mosi_n};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_tx.size() == 0) begin
                        n_cmp++;
                        n_bad++;
                        $display("FAIL R2 extra wire char: actual %0h expected none", sh);
                    end else begin
                        chk("R8 wire bit order", sh, exp_tx.pop_front());
                    end
                end
            end
        end
    end

    task automatic set_mode(input logic lsb, input logic pol, input logic pha,
                            input logic [7:0] dv, input logic inv);
        @(negedge clk);
        mon_en = 1'b0;
        cfg_lsb_first = lsb; cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv; miso_inv = inv;
        @(negedge clk);
        nbits = 0; have_last = 1'b0; toggles = 0; gap_err = 0;
        mon_en = 1'b1;
    endtask

    task automatic push(input logic [7:0] b, input logic to_wire, input logic to_rx);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        if (to_wire) exp_tx.push_back(b);
        if (to_rx)   exp_rx.push_back(b ^ {8{miso_inv}});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_one(input string req);
        logic [7:0] e;
        e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 8'h00;
        chk(req, rd_data, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (status[0] !== 1'b1);
        repeat (2) @(negedge clk);
        have_last = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 status after reset", status, 4'b0011);
        chk("R12 irq after reset", irq_rx_ovf, 0);
        chk("R12 rd_data after reset", rd_data, 0);
        chk("R1 sclk rest after reset", sclk, 0);

        // Burst of five into MSB-first, phase 0: fills transmit queue, overflows receive.
        set_mode(1'b0, 1'b0, 1'b0, 8'd1, 1'b0);
        push(8'hA5, 1, 1);
        chk("R3 idle drops on write", status[0], 0);
        push(8'h3C, 1, 1);
        push(8'hF0, 1, 1);
        push(8'h0F, 1, 1);
        push(8'h81, 1, 0);
        chk("R4 free low when 4 queued", status[1], 0);
        push(8'h66, 0, 0);   // R2 write into full queue is discarded
        do @(negedge clk); while (status[1] !== 1'b1);
        chk("R4 free returns while still shifting", status[0], 0);
        wait_idle();
        chk("R11 uniform clock spacing", gap_err, 0);
        chk("R2 only five chars clocked", toggles, 80);
        chk("R3 idle after last char", status[0], 1);
        chk("R6 overflow flag set", status[3], 1);
        chk("R6 one interrupt pulse", irq_cnt, 1);
        chk("R5 valid with unread data", status[2], 1);
        repeat (4) read_one("R5 received char");
        chk("R5 valid clears when drained", status[2], 0);
        chk("R7 overflow survives draining", status[3], 1);
        chk("R10 empty read value", rd_data, 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10 empty read leaves status", status, 4'b1011);
        chk("R10 empty read value after pop", rd_data, 0);
        @(negedge clk);
        stat_w1c_ovf = 1'b1;
        @(negedge clk);
        stat_w1c_ovf = 1'b0;
        chk("R7 overflow cleared by status write", status[3], 0);

        // All four clock modes with differing order, divider and inverted loopback.
        for (int m = 0; m < 4; m++) begin
            set_mode((m == 1) || (m == 2), m[1], m[0], 8'(m), m[0]);
            chk("R1 sclk rest level", sclk, m[1]);
            push(8'hC3 ^ 8'(m), 1, 1);
            push(8'h5A + 8'(m), 1, 1);
            push(8'h80 >> m, 1, 1);
            wait_idle();
            chk("R9 sixteen transitions per char", toggles, 48);
            chk("R11 no gap between chars", gap_err, 0);
            chk("R1 sclk back at rest", sclk, m[1]);
            repeat (3) read_one("R9 sampled MISO char");
        end

        // Completion into a full receive queue in the same cycle as a read.
        set_mode(1'b0, 1'b0, 1'b0, 8'd1, 1'b0);
        push(8'h11, 1, 1);
        push(8'h22, 1, 1);
        push(8'h33, 1, 1);
        push(8'h44, 1, 1);
        wait_idle();
        chk("R6 queue full before fifth", status[2], 1);
        base = toggles;
        push(8'h55, 1, 1);
        while (toggles < base + 15) @(negedge clk);
        @(negedge clk);
        chk("R6 head during same-cycle read", rd_data, exp_rx.pop_front());
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        wait_idle();
        chk("R6 no overflow when read frees slot", status[3], 0);
        chk("R6 no extra interrupt", irq_cnt, 1);
        repeat (4) read_one("R6 char kept by same-cycle read");
        chk("R5 drained", status[2], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule